// File: doc/BRIEF.md
# Serial-Number Arbitration Address Assigner

This block is the device-side logic that lets a controller on a shared two-wire bus (SCL clock, open-drain SDA data) hand out a volatile 8-bit bus ID to each device. The controller sends an assign frame. It opens with a START and a control byte. Next come the proposed ID byte and six serial-number bytes, and a STOP closes it. Every unassigned device that recognises the control byte acknowledges it and then acknowledges the ID byte. After that, all such devices shift out their fixed 48-bit serial numbers at the same time, most significant bit first.

SDA is a wired-AND line, so a pulled-low 0 overrides a released 1. A device that releases the line for a 1 but reads back a 0 has lost. It falls silent until the next START. Only the device with the numerically lowest serial number survives all 48 bits. That device takes the proposed ID when the STOP arrives in its proper place, which is right after the controller's NACK that follows the sixth serial byte. A STOP anywhere else abandons the frame for everyone.

An assigned device keeps its ID and ignores later assign frames. Reset or a clear pulse returns it to ID 00h and unassigned. The controller repeats the frame with fresh IDs until no device acknowledges any more. A detect output can flag, on request from the control byte, every unassigned device that took part in a frame.

Top module: `idarb_assigner`

## Requirements
- R1: After reset the ID output is 00h, the assigned flag is 0, detect is 0 and the SDA pull output is 0 (line released).
- R2: SDA is sampled on rising SCL. START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. An unassigned device pulls SDA low in the ACK slot of a control byte whose bits, apart from the OE bit (bit position OE_POS, default 0), equal ASSIGN_CODE (default F8h). Any other control byte gets no ACK, and the device leaves SDA released until the next START.
- R3: After an acknowledged control byte, the device pulls SDA low in the ACK slot after the ID byte.
- R4: In the serial phase the device drives its serial number MSB first: a 0 bit pulls SDA low and a 1 bit releases it. The pull output changes only while SCL is low.
- R5: A device that releases SDA for a 1 bit and samples SDA low at that rising SCL releases SDA for the rest of the frame and is not assigned. When several devices compete, only the one with the lowest serial number gets assigned.
- R6: The device releases SDA during the controller's ACK/NACK slot after each serial byte.
- R7: A STOP that follows the NACK slot after the sixth serial byte sets the assigned flag and loads the received ID byte into the ID output on the device that kept arbitration.
- R8: A STOP at any other point of the frame ends it with no device assigned and the ID unchanged.
- R9: An assigned device does not acknowledge an assign control byte and takes no part in the frame.
- R10: A clear pulse resets the ID to 00h and the assigned flag to 0. The device then takes part in assign frames again.
- R11: If the OE bit of an accepted control byte is 1, the detect output rises after the ACK slot of the ID byte and stays high until the next START or STOP. With the OE bit 0, detect stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Resolved (wired-AND) bus data line level |
| clear_i | input | 1 | One-cycle pulse that drops the assigned ID |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |
| detect_o | output | 1 | Detect flag for unassigned participants |
| assigned_o | output | 1 | Device holds an assigned ID |
| id_o | output | 8 | Current bus ID |

## Verification
A wrong frame position shows on SDA within one bit time: an ACK missing or misplaced, a serial byte read back shifted, or a bit pulled when it should be released. In a wrong arbitration state, a losing device keeps pulling after its loss. The controller then reads a corrupted byte in that same byte. A wrong STOP decision appears on the assigned flag and ID a couple of clocks after the STOP. The bench therefore runs several devices on one wired-AND line. It reads back every ACK and serial byte, and it watches each pull output for changes while SCL is high.

// File: rtl/idarb_pkg.sv
package idarb_pkg;

    typedef enum logic [3:0] {
        FS_IDLE,
        FS_CTRL,
        FS_CTRL_ACK,
        FS_ID,
        FS_ID_ACK,
        FS_SER,
        FS_SER_ACK,
        FS_FIN,
        FS_LOST
    } frame_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    localparam int BYTE_W = 8;

    function automatic logic ctrl_match(input logic [BYTE_W-1:0] got,
                                        input logic [BYTE_W-1:0] want,
                                        input logic [BYTE_W-1:0] ignore);
        return ((got ^ want) & ~ignore) == '0;
    endfunction

endpackage

// File: rtl/idarb_line_watch.sv
module idarb_line_watch
    import idarb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic [1:0] scl_h;
    logic [1:0] sda_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_h <= 2'b11;
            sda_h <= 2'b11;
        end else begin
            scl_h <= {scl_h[0], scl_i};
            sda_h <= {sda_h[0], sda_i};
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_h[0] & ~scl_h[1];
        ev_o.scl_fall = ~scl_h[0] & scl_h[1];
        ev_o.start    = scl_h[0] & scl_h[1] & sda_h[1] & ~sda_h[0];
        ev_o.stop     = scl_h[0] & scl_h[1] & ~sda_h[1] & sda_h[0];
        ev_o.sda      = sda_h[0];
    end

endmodule

// File: rtl/idarb_frame_ctl.sv
module idarb_frame_ctl
    import idarb_pkg::*;
#(
    parameter logic [7:0] ASSIGN_CODE = 8'hF8,
    parameter int         OE_POS      = 0,
    parameter int         SER_BYTES   = 6,
    parameter logic [SER_BYTES*8-1:0] SERIAL = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev_i,
    input  logic       assigned_i,
    output logic       pull_o,
    output logic       detect_o,
    output logic       commit_o,
    output logic [7:0] id_cand_o
);
    localparam int SER_W = SER_BYTES * BYTE_W;
    localparam int BC_W  = $clog2(SER_BYTES + 1);
    localparam logic [BYTE_W-1:0] OE_MASK = 8'(1) << OE_POS;
    localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(SER_BYTES);

    frame_st_e          st;
    logic [2:0]         bit_cnt;
    logic [BC_W-1:0]    byte_cnt;
    logic [BYTE_W-1:0]  sh;
    logic [BYTE_W-1:0]  byte_in;
    logic [SER_W-1:0]   ser_sh;
    logic               ack_seen;
    logic               oe_req;
    logic               drv;
    logic               det;

    assign byte_in = {sh[BYTE_W-2:0], ev_i.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FS_IDLE;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            sh        <= '0;
            ser_sh    <= '0;
            ack_seen  <= 1'b0;
            oe_req    <= 1'b0;
            drv       <= 1'b0;
            det       <= 1'b0;
            commit_o  <= 1'b0;
            id_cand_o <= '0;
        end else begin
            commit_o <= 1'b0;
            if (ev_i.start) begin
                st      <= FS_CTRL;
                bit_cnt <= '0;
                drv     <= 1'b0;
                det     <= 1'b0;
            end else if (ev_i.stop) begin
                if (st == FS_FIN) commit_o <= 1'b1;
                st  <= FS_IDLE;
                drv <= 1'b0;
                det <= 1'b0;
            end else begin
                case (st)
                    FS_CTRL: begin
                        if (ev_i.scl_rise) begin
                            sh      <= byte_in;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                if (ctrl_match(byte_in, ASSIGN_CODE, OE_MASK) && !assigned_i) begin
                                    st       <= FS_CTRL_ACK;
                                    ack_seen <= 1'b0;
                                    oe_req   <= byte_in[OE_POS];
                                end else begin
                                    st <= FS_IDLE;
                                end
                            end
                        end
                    end
                    FS_CTRL_ACK: begin
                        if (ev_i.scl_rise) ack_seen <= 1'b1;
                        if (ev_i.scl_fall) begin
                            if (!ack_seen) begin
                                drv <= 1'b1;
                            end else begin
                                drv     <= 1'b0;
                                bit_cnt <= '0;
                                st      <= FS_ID;
                            end
                        end
                    end
                    FS_ID: begin
                        if (ev_i.scl_rise) begin
                            sh      <= byte_in;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                id_cand_o <= byte_in;
                                st        <= FS_ID_ACK;
                                ack_seen  <= 1'b0;
                            end
                        end
                    end
                    FS_ID_ACK: begin
                        if (ev_i.scl_rise) ack_seen <= 1'b1;
                        if (ev_i.scl_fall) begin
                            if (!ack_seen) begin
                                drv <= 1'b1;
                            end else begin
                                drv      <= ~SERIAL[SER_W-1];
                                ser_sh   <= SERIAL;
                                byte_cnt <= '0;
                                bit_cnt  <= '0;
                                det      <= oe_req;
                                st       <= FS_SER;
                            end
                        end
                    end
                    FS_SER: begin
                        if (ev_i.scl_rise) begin
                            if (!drv && !ev_i.sda) begin
                                st <= FS_LOST;
                            end else begin
                                ser_sh  <= {ser_sh[SER_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 3'd1;
                                if (bit_cnt == 3'd7) begin
                                    byte_cnt <= byte_cnt + 1'b1;
                                    ack_seen <= 1'b0;
                                    st       <= FS_SER_ACK;
                                end
                            end
                        end
                        if (ev_i.scl_fall) drv <= ~ser_sh[SER_W-1];
                    end
                    FS_SER_ACK: begin
                        if (ev_i.scl_rise) begin
                            if (byte_cnt == LAST_BYTE) begin
                                st       <= FS_FIN;
                                ack_seen <= 1'b0;
                            end else begin
                                ack_seen <= 1'b1;
                            end
                        end
                        if (ev_i.scl_fall) begin
                            if (!ack_seen) begin
                                drv <= 1'b0;
                            end else begin
                                drv     <= ~ser_sh[SER_W-1];
                                bit_cnt <= '0;
                                st      <= FS_SER;
                            end
                        end
                    end
                    FS_FIN: begin
                        if (ev_i.scl_rise) begin
                            if (ack_seen) st <= FS_IDLE;
                            else ack_seen <= 1'b1;
                        end
                    end
                    FS_LOST: begin
                        drv <= 1'b0;
                    end
                    default: begin
                        drv <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign pull_o   = drv;
    assign detect_o = det;

    assert_pull_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv) |-> $past(ev_i.scl_fall));

    assert_lost_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (st == FS_LOST) |-> !drv);

    assert_host_slot_free_R6: assert property (@(posedge clk) disable iff (rst)
        (st == FS_SER_ACK && ack_seen) |-> !drv);

    assert_no_ack_when_owned_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv) && st == FS_CTRL_ACK) |-> !assigned_i);

endmodule

// File: rtl/idarb_id_store.sv
module idarb_id_store #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear_i,
    input  logic            commit_i,
    input  logic [ID_W-1:0] cand_i,
    output logic [ID_W-1:0] id_o,
    output logic            assigned_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            id_o       <= '0;
            assigned_o <= 1'b0;
        end else if (commit_i) begin
            id_o       <= cand_i;
            assigned_o <= 1'b1;
        end
    end

    assert_take_id_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !clear_i) |=> (assigned_o && id_o == $past(cand_i)));

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (id_o == '0 && !assigned_o));

endmodule

// File: rtl/idarb_assigner.sv
module idarb_assigner
    import idarb_pkg::*;
#(
    parameter logic [7:0] ASSIGN_CODE = 8'hF8,
    parameter int         OE_POS      = 0,
    parameter int         SER_BYTES   = 6,
    parameter logic [SER_BYTES*8-1:0] SERIAL = 48'h8000_0000_0001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       clear_i,
    output logic       sda_pull_o,
    output logic       detect_o,
    output logic       assigned_o,
    output logic [7:0] id_o
);
    line_ev_t   ev;
    logic       commit;
    logic [7:0] cand;

    idarb_line_watch u_watch (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    idarb_frame_ctl #(
        .ASSIGN_CODE (ASSIGN_CODE),
        .OE_POS      (OE_POS),
        .SER_BYTES   (SER_BYTES),
        .SERIAL      (SERIAL)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .assigned_i (assigned_o),
        .pull_o     (sda_pull_o),
        .detect_o   (detect_o),
        .commit_o   (commit),
        .id_cand_o  (cand)
    );

    idarb_id_store #(.ID_W(BYTE_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_i),
        .commit_i   (commit),
        .cand_i     (cand),
        .id_o       (id_o),
        .assigned_o (assigned_o)
    );

    assert_detect_unowned_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(detect_o) |-> !assigned_o);

endmodule

// File: tb/idarb_assigner_bench.sv
module idarb_assigner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam logic [47:0] SER_A = 48'h8000_0000_0001;
    localparam logic [47:0] SER_B = 48'h3C5A_0000_0F00;
    localparam logic [47:0] SER_C = 48'h3C5A_0000_0E80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic mpull = 1'b0;
    logic clr_a = 1'b0, clr_b = 1'b0, clr_c = 1'b0;
    logic p_a, p_b, p_c, d_a, d_b, d_c, s_a, s_b, s_c;
    logic [7:0] id_a, id_b, id_c;
    logic sda_bus;
    int checks = 0;
    int errors = 0;
    int viol = 0;
    logic scl_q = 1'b1;
    logic [2:0] pull_q = '0;

    assign sda_bus = ~(mpull | p_a | p_b | p_c);

    always #(CLK_PERIOD/2) clk = ~clk;

    idarb_assigner #(.SERIAL(SER_A)) u_idarb_assigner (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .clear_i(clr_a),
        .sda_pull_o(p_a), .detect_o(d_a), .assigned_o(s_a), .id_o(id_a));
    idarb_assigner #(.SERIAL(SER_B)) u_idarb_assigner_b (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .clear_i(clr_b),
        .sda_pull_o(p_b), .detect_o(d_b), .assigned_o(s_b), .id_o(id_b));
    idarb_assigner #(.SERIAL(SER_C)) u_idarb_assigner_c (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .clear_i(clr_c),
        .sda_pull_o(p_c), .detect_o(d_c), .assigned_o(s_c), .id_o(id_c));

    // R4 monitor: a pull output must not change while SCL stays high
    always @(posedge clk) begin
        if (!rst && scl && scl_q && ({p_c, p_b, p_a} != pull_q)) viol++;
        scl_q  <= scl;
        pull_q <= {p_c, p_b, p_a};
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(Q); mpull = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; mpull = 1'b1; tick(Q); scl = 1'b1; tick(Q); mpull = 1'b0; tick(2*Q);
    endtask

    task automatic put_bit(input logic b, output logic got, output logic [2:0] pl);
        mpull = ~b; tick(2*Q); scl = 1'b1; tick(Q);
        got = sda_bus; pl = {p_c, p_b, p_a};
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic g; logic [2:0] pl;
        for (int i = 7; i >= 0; i--) put_bit(v[i], g, pl);
        put_bit(1'b1, ack, pl);
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] v);
        logic g; logic [2:0] pl;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            put_bit(1'b1, g, pl);
            v = {v[6:0], g};
        end
        put_bit(last, g, pl);
        chk("R6 devices free in host slot", {45'd0, pl}, 48'd0);
    endtask

    task automatic t_reset();
        chk("R1 ids", {24'd0, id_c, id_b, id_a}, 48'd0);
        chk("R1 flags", {39'd0, s_c, s_b, s_a, d_c, d_b, d_a, p_c, p_b, p_a}, 48'd0);
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] v;
        bus_start();
        send_byte(8'h55, a);
        chk("R2 foreign control byte not acked", {47'd0, a}, 48'd1);
        recv_byte(1'b1, v);
        chk("R2 line stays released", {40'd0, v}, 48'hFF);
        bus_stop();
    endtask

    task automatic t_misplaced_stop();
        logic a, g; logic [2:0] pl;
        bus_start();
        send_byte(8'hF9, a);
        chk("R2 assign code acked", {47'd0, a}, 48'd0);
        send_byte(8'h21, a);
        chk("R3 id byte acked", {47'd0, a}, 48'd0);
        chk("R11 detect with OE set", {45'd0, d_c, d_b, d_a}, 48'h7);
        put_bit(1'b1, g, pl);
        chk("R4 first serial bit", {47'd0, g}, 48'd0);
        put_bit(1'b1, g, pl);
        bus_stop();
        tick(4);
        chk("R8 nobody assigned", {45'd0, s_c, s_b, s_a}, 48'd0);
        chk("R8 ids unchanged", {24'd0, id_c, id_b, id_a}, 48'd0);
        chk("R11 detect dropped at stop", {45'd0, d_c, d_b, d_a}, 48'd0);
    endtask

    task automatic t_assign(input logic [7:0] idv, input logic [47:0] exp_ser,
                            input logic [2:0] exp_asg, input logic [23:0] exp_ids);
        logic a; logic [7:0] v; logic [47:0] got;
        bus_start();
        send_byte(8'hF8, a);
        chk("R2 assign code acked", {47'd0, a}, 48'd0);
        send_byte(idv, a);
        chk("R3 id byte acked", {47'd0, a}, 48'd0);
        chk("R11 detect low with OE clear", {45'd0, d_c, d_b, d_a}, 48'd0);
        got = '0;
        for (int k = 0; k < 6; k++) begin
            recv_byte(k == 5, v);
            got = {got[39:0], v};
        end
        chk("R4 R5 lowest serial on bus", got, exp_ser);
        bus_stop();
        tick(4);
        chk("R7 R5 assigned flags", {45'd0, s_c, s_b, s_a}, {45'd0, exp_asg});
        chk("R7 R9 ids", {24'd0, id_c, id_b, id_a}, {24'd0, exp_ids});
    endtask

    task automatic t_all_assigned();
        logic a;
        bus_start();
        send_byte(8'hF8, a);
        chk("R9 assigned devices stay silent", {47'd0, a}, 48'd1);
        bus_stop();
    endtask

    task automatic t_clear();
        tick(1); clr_c = 1'b1; tick(1); clr_c = 1'b0; tick(2);
        chk("R10 clear drops id", {40'd0, id_c}, 48'd0);
        chk("R10 clear drops flag", {47'd0, s_c}, 48'd0);
        t_assign(8'h30, SER_C, 3'b111, {8'h30, 8'h22, 8'h23});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5); rst = 1'b0; tick(4);
        t_reset();
        t_mismatch();
        t_misplaced_stop();
        t_assign(8'h21, SER_C, 3'b100, {8'h21, 8'h00, 8'h00});
        t_assign(8'h22, SER_B, 3'b110, {8'h21, 8'h22, 8'h00});
        t_assign(8'h23, SER_A, 3'b111, {8'h21, 8'h22, 8'h23});
        t_all_assigned();
        t_clear();
        chk("R4 pulls only move while SCL low", 48'(viol), 48'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule